// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers interrupt conditions from five sources and turns them into a single request to a processor core, together with the entry address that the core should jump to. Every source owns a pending flag that records its condition. Every source also has an enable bit in a mask register, and one global enable gates the whole request. The flags record events even while they are masked. This lets software poll a source without ever taking it as an interrupt.

When the core acknowledges the request, the controller picks the highest-priority source whose flag and mask bit are both set. It latches that source's entry address and clears the global enable, so that no second interrupt is taken until software allows it. A source's flag is cleared only when software reads the register that holds it, and that read clears every flag in the register. Software must therefore keep the value it read and test the bits from that copy.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all flags, all mask bits and the global enable read as 0, `irq_req` is low and `irq_vec` is 12'h000.
- R2: A one-cycle pulse on `src_evt[i]` sets flag i at the next clock edge, whatever mask bit i holds.
- R3: `irq_req` is high exactly when the global enable is set and at least one source has both its flag and its mask bit set. A flag whose mask bit is clear raises no request.
- R4: Flags of sources 0 to 3 read at address 0 in bits 3:0, and the flag of source 4 reads at address 1 in bit 0. A read returns the flags as they stood before the read and clears every flag at that address. Flags at the other address are left as they were.
- R5: The global enable is written through bit 0 at address 3 and reads back there. An acknowledge clears it at the next edge, and the acknowledge wins over a write to address 3 in the same cycle.
- R6: While a flag stays set and unmasked, setting the global enable again raises `irq_req` again.
- R7: On `irq_ack`, `irq_vec` loads the entry address of the highest-numbered source that has both its flag and its mask bit set. Source 0 maps to 12'h102, source 1 to 12'h104, source 2 to 12'h106, source 3 to 12'h10A and source 4 to 12'h10E.
- R8: `irq_vec` changes only on an acknowledge. A higher-priority flag that arrives after the acknowledge does not alter it.
- R9: When a source event and a clearing read hit the same flag in one cycle, the flag ends up set.
- R10: The mask is written and read at address 2, with bit i for source i. Writes to addresses 0 and 1 have no effect on the flags.
- R11: An acknowledge when no flag is both set and unmasked leaves `irq_vec` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_evt | input | 5 | Per-source condition pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears flags at flag addresses) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 5 | Write data |
| bus_rdata | output | 5 | Read data for the addressed register, combinational |
| irq_ack | input | 1 | Core acknowledge, one cycle |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 12 | Latched entry address |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together and that `irq_ack` is a single-cycle pulse. They also assume that source events are pulses whose effect is judged one edge later. The stimulus keeps to these rules because every strobe is raised at a falling edge, held for exactly one rising edge and dropped at the next falling edge. Cases where two things happen in one cycle, such as an event together with a clearing read, or an acknowledge together with an enable write, are built on purpose with distinct strobes. They never combine a read with a write.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Holds the sizing constants and the entry-address table of the
// interrupt controller. Assumes at most FLAGS_PER_REG <= NUM_SRC.
package irq_pkg;
    parameter int NUM_SRC       = 5;
    parameter int FLAGS_PER_REG = 4;
    parameter int ADDR_W        = 2;
    parameter int VEC_W         = 12;

    localparam int DATA_W        = NUM_SRC;
    localparam int NUM_FLAG_REGS = (NUM_SRC + FLAGS_PER_REG - 1) / FLAGS_PER_REG;
    localparam int REG_MASK      = NUM_FLAG_REGS;
    localparam int REG_GIE       = NUM_FLAG_REGS + 1;
    localparam int IDX_W         = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef logic [IDX_W-1:0] src_idx_t;
    typedef logic [VEC_W-1:0] vec_t;

    // Entry address of a source; higher index means higher priority.
    function automatic vec_t entry_of(input src_idx_t idx);
        case (idx)
            3'd0:    entry_of = 12'h102;
            3'd1:    entry_of = 12'h104;
            3'd2:    entry_of = 12'h106;
            3'd3:    entry_of = 12'h10A;
            default: entry_of = 12'h10E;
        endcase
    endfunction
endpackage

// File: rtl/irq_flag_bank.sv
// Module irq_flag_bank
// Holds one pending flag per source. An event sets its flag, and a
// clear strobe for a register group clears all flags of that group.
// The set wins over the clear. Assumes clr_grp is already decoded
// from a bus read.
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_evt,
    input  logic [NUM_FLAG_REGS-1:0] clr_grp,
    output logic [NUM_SRC-1:0]       flags
);
    // Update every flag: set on event, else clear on group read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (src_evt[i])
                    flags[i] <= 1'b1;
                else if (clr_grp[i / FLAGS_PER_REG])
                    flags[i] <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        localparam int GRP = g / FLAGS_PER_REG;

        p_evt_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
            src_evt[g] |=> flags[g]);

        p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_grp[GRP] && !src_evt[g]) |=> !flags[g]);

        p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_grp[GRP] && src_evt[g]) |=> flags[g]);
    end
endmodule

// File: rtl/irq_prio_sel.sv
// Module irq_prio_sel
// Fixed-priority selector: reports whether any source is pending and
// the index of the highest-numbered one. Purely combinational.
module irq_prio_sel
    import irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] pending,
    output logic               any,
    output src_idx_t           idx
);
    // Scan upward so the highest pending index is the one kept.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pending[i]) begin
                any = 1'b1;
                idx = src_idx_t'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module irq_vector_ctrl
// Top of the interrupt controller: register decode, mask and global
// enable, the request output and the entry-address latch. Assumes a
// single-cycle irq_ack and that bus_wr and bus_rd are not both high.
module irq_vector_ctrl
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               irq_ack,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec
);
    logic [NUM_SRC-1:0]       flags;
    logic [NUM_SRC-1:0]       mask_q;
    logic                     gie_q;
    logic [NUM_FLAG_REGS-1:0] clr_grp;
    logic [NUM_SRC-1:0]       pending;
    logic                     sel_any;
    src_idx_t                 sel_idx;
    vec_t                     vec_q;

    // Decode a read of a flag register into a group clear strobe.
    always_comb begin
        for (int g = 0; g < NUM_FLAG_REGS; g++)
            clr_grp[g] = bus_rd && (int'(bus_addr) == g);
    end

    irq_flag_bank u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_evt (src_evt),
        .clr_grp (clr_grp),
        .flags   (flags)
    );

    assign pending = flags & mask_q;

    irq_prio_sel u_sel (
        .pending (pending),
        .any     (sel_any),
        .idx     (sel_idx)
    );

    // Mask register, written at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (bus_wr && int'(bus_addr) == REG_MASK)
            mask_q <= bus_wdata;
    end

    // Global enable: cleared by acknowledge, which beats a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gie_q <= 1'b0;
        else if (irq_ack)
            gie_q <= 1'b0;
        else if (bus_wr && int'(bus_addr) == REG_GIE)
            gie_q <= bus_wdata[0];
    end

    // Entry address latch, loaded only on acknowledge with a winner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_q <= '0;
        else if (irq_ack && sel_any)
            vec_q <= entry_of(sel_idx);
    end

    // Read mux for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) == REG_MASK) begin
            bus_rdata = mask_q;
        end else if (int'(bus_addr) == REG_GIE) begin
            bus_rdata[0] = gie_q;
        end else begin
            for (int i = 0; i < NUM_SRC; i++)
                if ((i / FLAGS_PER_REG) == int'(bus_addr))
                    bus_rdata[i % FLAGS_PER_REG] = flags[i];
        end
    end

    assign irq_req = gie_q && sel_any;
    assign irq_vec = vec_q;

    p_ack_clears_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !gie_q);

    p_req_drops_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_req);

    p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_ack |=> $stable(irq_vec));

    p_sel_is_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_any |-> pending[sel_idx]);

    p_vec_in_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && sel_any) |=> (irq_vec == 12'h102 || irq_vec == 12'h104 ||
                                  irq_vec == 12'h106 || irq_vec == 12'h10A ||
                                  irq_vec == 12'h10E));
endmodule

// File: tb/irq_vector_ctrl_test.sv
// Directed bench for irq_vector_ctrl. Inputs change on falling edges,
// and outputs are sampled on falling edges.
module irq_vector_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_evt = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [4:0]  bus_wdata = '0;
    logic [4:0]  bus_rdata;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [11:0] irq_vec;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irq_vector_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_evt   (src_evt),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_ack   (irq_ack),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec)
    );

    function automatic logic [11:0] exp_vec(input int s);
        case (s)
            0: return 12'h102;
            1: return 12'h104;
            2: return 12'h106;
            3: return 12'h10A;
            default: return 12'h10E;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [4:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [4:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic evt(input logic [4:0] v);
        src_evt = v;
        tick();
        src_evt = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [4:0] d;
        chk("R1 irq_req", irq_req, 0);
        chk("R1 irq_vec", irq_vec, 12'h000);
        rd(2, d); chk("R1 mask", d, 0);
        rd(3, d); chk("R1 gie", d, 0);
        rd(0, d); chk("R1 flags lo", d, 0);
        rd(1, d); chk("R1 flags hi", d, 0);
    endtask

    task automatic t_masked_flag();
        logic [4:0] d;
        evt(5'b00100);
        wr(3, 5'd1);
        chk("R3 masked no req", irq_req, 0);
        rd(0, d); chk("R2 flag set while masked", d, 5'h4);
        rd(0, d); chk("R4 read cleared", d, 0);
        wr(3, 5'd0);
    endtask

    task automatic t_groups();
        logic [4:0] d;
        evt(5'b10010);
        rd(1, d); chk("R4 addr1 src4", d, 5'h1);
        rd(0, d); chk("R4 addr0 untouched by addr1 read", d, 5'h2);
        rd(1, d); chk("R4 addr1 cleared", d, 0);
        rd(0, d); chk("R4 addr0 cleared", d, 0);
    endtask

    task automatic t_set_wins();
        logic [4:0] d;
        src_evt = 5'b00001; bus_rd = 1'b1; bus_addr = 2'd0;
        tick();
        src_evt = '0; bus_rd = 1'b0;
        rd(0, d); chk("R9 set beats clear", d, 5'h1);
        rd(0, d); chk("R9 then cleared", d, 0);
    endtask

    task automatic t_write_ignored();
        logic [4:0] d;
        wr(0, 5'h1F);
        wr(1, 5'h1F);
        rd(0, d); chk("R10 write addr0 ignored", d, 0);
        rd(1, d); chk("R10 write addr1 ignored", d, 0);
        wr(2, 5'h15);
        rd(2, d); chk("R10 mask readback", d, 5'h15);
    endtask

    task automatic t_vector_map();
        logic [4:0] d;
        wr(2, 5'h1F);
        for (int s = 0; s < 5; s++) begin
            evt(5'(1 << s));
            ack();
            chk("R7 single source entry", irq_vec, exp_vec(s));
            rd(0, d);
            rd(1, d);
        end
    endtask

    task automatic t_priority();
        logic [4:0] d;
        wr(2, 5'h1F);
        evt(5'b01001);
        chk("R3 no req with gie clear", irq_req, 0);
        wr(3, 5'd1);
        chk("R3 req raised", irq_req, 1);
        ack();
        chk("R7 highest of 0 and 3", irq_vec, 12'h10A);
        chk("R5 req low after ack", irq_req, 0);
        rd(3, d); chk("R5 gie cleared by ack", d, 0);
        wr(3, 5'd1);
        chk("R6 req again with flag left set", irq_req, 1);
        evt(5'b10000);
        chk("R8 vec held after late source", irq_vec, 12'h10A);
        ack();
        chk("R7 src4 wins", irq_vec, 12'h10E);
        rd(0, d);
        rd(1, d);
        wr(3, 5'd1);
        chk("R6 no req when flags clear", irq_req, 0);
        wr(3, 5'd0);
    endtask

    task automatic t_mask_select();
        logic [4:0] d;
        wr(2, 5'b00001);
        evt(5'b10001);
        ack();
        chk("R7 masked src4 not chosen", irq_vec, 12'h102);
        rd(0, d);
        rd(1, d);
        wr(2, 5'h1F);
        evt(5'b00100);
        rd(0, d);
        ack();
        chk("R11 ack with nothing pending", irq_vec, 12'h102);
    endtask

    task automatic t_ack_vs_write();
        logic [4:0] d;
        irq_ack = 1'b1; bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 5'd1;
        tick();
        irq_ack = 1'b0; bus_wr = 1'b0;
        rd(3, d); chk("R5 ack beats gie write", d, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked_flag();
        t_groups();
        t_set_wins();
        t_write_ignored();
        t_vector_map();
        t_priority();
        t_mask_select();
        t_ack_vs_write();
        finish_run();
    end
endmodule